// File: doc/BRIEF.md
# Receiver Shutdown Sequencer

This block brings an attached radio receiver into its lowest-power state through the receiver's register port. It is started by a one-cycle request. It then runs a fixed chain of read-modify-write operations. Each read fetches the current contents of a register. The matching write sends that word back with only the shutdown-related fields changed, so every other bit the device holds is kept.

There is an optional first pair that tristates the audio outputs. The gpio/interrupt register is then parked in its lowest-current setting. The control register is written last, with mute engaged and both the enable and disable bits raised. After that write, the block reads the control register again and again until the device reports that its internal shutdown has finished. A bounded wait guards this poll.

The register port is a plain request/acknowledge model. A read or write request stays up, with a steady address and data, until the device returns a one-cycle acknowledge. Read data is valid in the acknowledge cycle.

Top module: `rx_pwrdown_seq`

## Requirements
- R1: While reset is low and whenever the block is idle, busWrReq, busRdReq, busy, doneP and timeoutP are all 0.
- R2: A start request seen while idle with hizOpt=1 produces these transactions in order: read 07h, write 07h, read 04h, write 04h, read 02h, write 02h, then repeated reads of 02h. With hizOpt=0 the two 07h transactions are left out.
- R3: The write to 07h carries the word last read from 07h with bit 14 (audio tristate) set and all other bits unchanged.
- R4: The write to 04h carries the word last read from 04h with bits [5:4] = 10b and bits [1:0] = 10b, and all other bits unchanged.
- R5: The write to 02h carries the word last read from 02h with bit 15 (mute off) cleared and bit 0 (enable) and bit 6 (disable) set, and all other bits unchanged.
- R6: Every write to 02h has both bit 0 and bit 6 set. Enable is never dropped alone.
- R7: A request keeps its kind, address and write data stable until its acknowledge. Read and write are never requested together. A new transaction starts no earlier than the cycle after the previous acknowledge.
- R8: After the 02h write is acknowledged, 02h is polled. On the first poll acknowledge whose data has bit 0 = 0 and bit 6 = 0, doneP is 1 for exactly the next cycle and busy falls in that same cycle.
- R9: If TIMEOUT_CYC poll cycles pass with no such read, timeoutP is 1 for exactly one cycle. busy falls and requests stop, and doneP does not rise.
- R10: A start request while busy has no effect on the running sequence or its option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin the shutdown sequence (sampled when idle) |
| hizOpt | input | 1 | Include the audio tristate step (sampled with startReq) |
| busAck | input | 1 | One-cycle acknowledge of the pending transaction |
| busRdata | input | 16 | Read data, valid with busAck on a read |
| busWrReq | output | 1 | Write request |
| busRdReq | output | 1 | Read request |
| busAddr | output | 8 | Register address |
| busWdata | output | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| doneP | output | 1 | One-cycle success pulse |
| timeoutP | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with TIMEOUT_CYC = 60 in place of the default 320000 (1.5 ms plus margin at 200 MHz). This lets a device that never clears its bits drive the timeout exit within a short run. The device model answers with acknowledge latencies of 0, 1 and 3 cycles and clears the control bits after a programmable delay. This exercises held requests, repeated polls and back-to-back transactions. A start request pulsed mid-sequence with the other option value shows that a running sequence is not disturbed.

// File: rtl/rx_pwrdown_pkg.sv
`timescale 1ns/1ps
package rx_pwrdown_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 8'h02;
  localparam logic [ADDR_W-1:0] REG_GPIO  = 8'h04;
  localparam logic [ADDR_W-1:0] REG_AUDIO = 8'h07;

  localparam int BIT_EN      = 0;
  localparam int BIT_DIS     = 6;
  localparam int BIT_HIZ     = 14;
  localparam int BIT_MUTEOFF = 15;

  localparam logic [WORD_W-1:0] GPIO_CLR = 16'h0033;
  localparam logic [WORD_W-1:0] GPIO_SET = 16'h0022;

  typedef enum logic [1:0] {MOD_AUDIO, MOD_GPIO, MOD_CTRL} modSel_t;

  typedef struct packed {
    logic    capture;
    modSel_t sel;
    logic    timerClr;
    logic    timerRun;
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] modWord(modSel_t s, logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    case (s)
      MOD_AUDIO: r[BIT_HIZ] = 1'b1;
      MOD_GPIO:  r = (w & ~GPIO_CLR) | GPIO_SET;
      default: begin
        r[BIT_MUTEOFF] = 1'b0;
        r[BIT_EN]      = 1'b1;
        r[BIT_DIS]     = 1'b1;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rx_pwrdown_ctrl.sv
`timescale 1ns/1ps
module rx_pwrdown_ctrl
  import rx_pwrdown_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              hizOpt,
  input  logic              busAck,
  input  logic              allClear,
  input  logic              timerDone,
  output logic              busWrReq,
  output logic              busRdReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busy,
  output logic              doneP,
  output logic              timeoutP,
  output dpStrobe_t         stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_AUD, ST_WR_AUD, ST_RD_GP, ST_WR_GP, ST_RD_CT, ST_WR_CT, ST_POLL
  } state_t;

  state_t st, stNxt;
  logic pollOk, pollExpire;

  assign pollOk     = (st == ST_POLL) && busAck && allClear;
  assign pollExpire = (st == ST_POLL) && !pollOk && timerDone;

  always_comb begin
    stNxt        = st;
    stb          = '0;
    stb.sel      = MOD_CTRL;
    case (st)
      ST_IDLE:   if (startReq) stNxt = hizOpt ? ST_RD_AUD : ST_RD_GP;
      ST_RD_AUD: begin
        stb.sel = MOD_AUDIO;
        if (busAck) begin stb.capture = 1'b1; stNxt = ST_WR_AUD; end
      end
      ST_WR_AUD: if (busAck) stNxt = ST_RD_GP;
      ST_RD_GP: begin
        stb.sel = MOD_GPIO;
        if (busAck) begin stb.capture = 1'b1; stNxt = ST_WR_GP; end
      end
      ST_WR_GP:  if (busAck) stNxt = ST_RD_CT;
      ST_RD_CT:  if (busAck) begin stb.capture = 1'b1; stNxt = ST_WR_CT; end
      ST_WR_CT:  if (busAck) begin stb.timerClr = 1'b1; stNxt = ST_POLL; end
      ST_POLL: begin
        stb.timerRun = 1'b1;
        if (pollOk || pollExpire) stNxt = ST_IDLE;
      end
      default:   stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      doneP    <= 1'b0;
      timeoutP <= 1'b0;
    end else begin
      st       <= stNxt;
      doneP    <= pollOk;
      timeoutP <= pollExpire;
    end
  end

  always_comb begin
    busRdReq = 1'b0;
    busWrReq = 1'b0;
    busAddr  = '0;
    case (st)
      ST_RD_AUD: begin busRdReq = 1'b1; busAddr = REG_AUDIO; end
      ST_WR_AUD: begin busWrReq = 1'b1; busAddr = REG_AUDIO; end
      ST_RD_GP:  begin busRdReq = 1'b1; busAddr = REG_GPIO;  end
      ST_WR_GP:  begin busWrReq = 1'b1; busAddr = REG_GPIO;  end
      ST_RD_CT,
      ST_POLL:   begin busRdReq = 1'b1; busAddr = REG_CTRL;  end
      ST_WR_CT:  begin busWrReq = 1'b1; busAddr = REG_CTRL;  end
      default: ;
    endcase
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/rx_pwrdown_dp.sv
`timescale 1ns/1ps
module rx_pwrdown_dp
  import rx_pwrdown_pkg::*;
#(
  parameter int TIMEOUT_CYC = 320000
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busWdata,
  output logic              allClear,
  output logic              timerDone
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [WORD_W-1:0] shadow;
  logic [TW-1:0]     waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shadow <= '0;
    else if (stb.capture) shadow <= modWord(stb.sel, busRdata);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             waitCnt <= '0;
    else if (stb.timerClr) waitCnt <= '0;
    else if (stb.timerRun && waitCnt != LAST) waitCnt <= waitCnt + 1'b1;
  end

  assign busWdata  = shadow;
  assign allClear  = !busRdata[BIT_EN] && !busRdata[BIT_DIS];
  assign timerDone = (waitCnt == LAST);
endmodule

// File: rtl/rx_pwrdown_seq.sv
`timescale 1ns/1ps
module rx_pwrdown_seq
  import rx_pwrdown_pkg::*;
#(
  parameter int TIMEOUT_CYC = 320000
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        hizOpt,
  input  logic        busAck,
  input  logic [15:0] busRdata,
  output logic        busWrReq,
  output logic        busRdReq,
  output logic [7:0]  busAddr,
  output logic [15:0] busWdata,
  output logic        busy,
  output logic        doneP,
  output logic        timeoutP
);
  dpStrobe_t stb;
  logic allClear, timerDone;

  rx_pwrdown_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hizOpt(hizOpt), .busAck(busAck),
    .allClear(allClear), .timerDone(timerDone), .busWrReq(busWrReq), .busRdReq(busRdReq),
    .busAddr(busAddr), .busy(busy), .doneP(doneP), .timeoutP(timeoutP), .stb(stb)
  );

  rx_pwrdown_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busRdata(busRdata), .busWdata(busWdata),
    .allClear(allClear), .timerDone(timerDone)
  );
endmodule

// File: rtl/rx_pwrdown_chk.sv
`timescale 1ns/1ps
module rx_pwrdown_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busAck,
  input logic        busWrReq,
  input logic        busRdReq,
  input logic [7:0]  busAddr,
  input logic [15:0] busWdata,
  input logic        busy,
  input logic        doneP,
  input logic        timeoutP
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWrReq && !busRdReq));

  assert_audio_hiz_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrReq && busAddr == 8'h07) |-> busWdata[14]);

  assert_gpio_park_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrReq && busAddr == 8'h04) |-> (busWdata[5:4] == 2'b10 && busWdata[1:0] == 2'b10));

  assert_mute_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrReq && busAddr == 8'h02) |-> !busWdata[15]);

  assert_no_partial_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrReq && busAddr == 8'h02) |-> (busWdata[0] && busWdata[6]));

  assert_one_kind_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrReq && busRdReq));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((busWrReq || busRdReq) && !busAck) |=>
      (timeoutP || (busWrReq == $past(busWrReq) && busRdReq == $past(busRdReq) &&
                    $stable(busAddr) && (!busWrReq || $stable(busWdata)))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (!busy && !timeoutP));

  assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutP |=> !timeoutP);

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutP |-> !busy);
endmodule

bind rx_pwrdown_seq rx_pwrdown_chk chk_i (
  .clk(clk), .rstN(rstN), .busAck(busAck), .busWrReq(busWrReq), .busRdReq(busRdReq),
  .busAddr(busAddr), .busWdata(busWdata), .busy(busy), .doneP(doneP), .timeoutP(timeoutP)
);

// File: tb/rx_pwrdown_seq_tb_top.sv
`timescale 1ns/1ps
module rx_pwrdown_seq_tb_top;
  localparam int TO = 60;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic startReq = 1'b0, hizOpt = 1'b0, busAck = 1'b0;
  logic [15:0] busRdata = '0;
  logic busWrReq, busRdReq, busy, doneP, timeoutP;
  logic [7:0] busAddr;
  logic [15:0] busWdata;

  rx_pwrdown_seq #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hizOpt(hizOpt), .busAck(busAck),
    .busRdata(busRdata), .busWrReq(busWrReq), .busRdReq(busRdReq), .busAddr(busAddr),
    .busWdata(busWdata), .busy(busy), .doneP(doneP), .timeoutP(timeoutP)
  );

  initial forever #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0;
  logic snapRst, snapStart, snapHiz, snapAck;
  logic [15:0] snapRdata;

  // device model
  logic [15:0] dev [8];
  int lat = 1, clrDelay = 10, shutCnt = 0, reqCnt = 0, partial = 0;
  int wrCount [8];
  int txLog [$];
  logic [15:0] lastWr2;
  bit sawDone = 0, sawTo = 0;

  // reference model
  int q [$];
  int mTimer = 0;
  logic [15:0] lastRd = '0;
  bit mDone = 0, mTo = 0;

  function automatic logic [15:0] expWord(int a, logic [15:0] w);
    if (a == 7) return w | 16'h4000;
    if (a == 4) return {w[15:6], 2'b10, w[3:2], 2'b10};
    return {1'b0, w[14:7], 1'b1, w[5:1], 1'b1};
  endfunction

  function automatic bit diff(string tag, string nm, int act, int exp);
    if (act != exp) begin
      $display("FAIL %s: %s actual=%0h expected=%0h (cycle %0d)", tag, nm, act, exp, cycles);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(string tag, string nm, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic modelStep();
    int kind, a;
    mDone = 0; mTo = 0;
    if (!snapRst) begin q.delete(); return; end
    if (q.size() == 0) begin
      if (snapStart) begin
        if (snapHiz) begin q.push_back(7*4); q.push_back(7*4+1); end
        q.push_back(4*4); q.push_back(4*4+1);
        q.push_back(2*4); q.push_back(2*4+1); q.push_back(2*4+2);
      end
      return;
    end
    kind = q[0] % 4; a = q[0] / 4;
    if (kind == 0) begin
      if (snapAck) begin lastRd = snapRdata; void'(q.pop_front()); end
    end else if (kind == 1) begin
      if (snapAck) begin void'(q.pop_front()); if (a == 2) mTimer = 0; end
    end else begin
      if (snapAck && !snapRdata[0] && !snapRdata[6]) begin q.delete(); mDone = 1; end
      else if (mTimer == TO - 1) begin q.delete(); mTo = 1; end
      else mTimer++;
    end
  endtask

  task automatic compareAll();
    bit bad = 0;
    int kind = 3, a = 0;
    if (q.size() > 0) begin kind = q[0] % 4; a = q[0] / 4; end
    bad |= diff("R1", "busy", busy, q.size() > 0);
    bad |= diff("R7", "busRdReq", busRdReq, kind == 0 || kind == 2);
    bad |= diff("R7", "busWrReq", busWrReq, kind == 1);
    if (kind != 3) bad |= diff("R2", "busAddr", busAddr, a);
    if (kind == 1)
      bad |= diff(a == 7 ? "R3" : (a == 4 ? "R4" : "R5"), "busWdata", busWdata, expWord(a, lastRd));
    bad |= diff("R8", "doneP", doneP, mDone);
    bad |= diff("R9", "timeoutP", timeoutP, mTo);
    compared++;
    if (bad) mismatched++;
  endtask

  task automatic deviceStep();
    if (shutCnt > 0) begin
      shutCnt--;
      if (shutCnt == 0) begin dev[2][0] = 1'b0; dev[2][6] = 1'b0; end
    end
    if (busAck) busAck = 1'b0;
    else if (busRdReq || busWrReq) begin
      if (reqCnt >= lat) begin
        busAck = 1'b1; reqCnt = 0;
        txLog.push_back(int'(busAddr) * 2 + int'(busWrReq));
        if (busRdReq) busRdata = dev[busAddr[2:0]];
        else begin
          dev[busAddr[2:0]] = busWdata;
          wrCount[busAddr[2:0]]++;
          if (busAddr == 8'h02) begin
            lastWr2 = busWdata;
            if (busWdata[0] && !busWdata[6]) partial++;
            if (busWdata[0] && busWdata[6] && clrDelay > 0) shutCnt = clrDelay;
          end
        end
      end else reqCnt++;
    end else reqCnt = 0;
    if (doneP) sawDone = 1;
    if (timeoutP) sawTo = 1;
  endtask

  initial forever begin
    @(posedge clk);
    snapRst = rstN; snapStart = startReq; snapHiz = hizOpt;
    snapAck = busAck; snapRdata = busRdata;
    started = 1;
  end

  initial forever begin
    @(negedge clk);
    if (started) begin
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
      modelStep();
      compareAll();
      deviceStep();
    end
  end

  task automatic prep(int l, int cd, logic [15:0] r7, logic [15:0] r4, logic [15:0] r2);
    lat = l; clrDelay = cd;
    dev[7] = r7; dev[4] = r4; dev[2] = r2;
    for (int i = 0; i < 8; i++) wrCount[i] = 0;
    txLog.delete(); partial = 0; sawDone = 0; sawTo = 0;
  endtask

  task automatic pulseStart(logic h);
    @(negedge clk); startReq = 1'b1; hizOpt = h;
    @(negedge clk); startReq = 1'b0; hizOpt = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (sawDone || sawTo) break;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) dev[i] = '0;
    #1 rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "reset busy/req/done/to", {busy, busWrReq, busRdReq, doneP, timeoutP}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle after reset", {busy, busWrReq, busRdReq, doneP, timeoutP}, 0);

    // Scenario A: tristate option on, latency 1, device clears after 20 cycles
    prep(1, 20, 16'h3C04, 16'h0008, 16'h8001);
    pulseStart(1'b1);
    waitEnd();
    check("R8", "done seen", sawDone, 1);
    check("R9", "no timeout", sawTo, 0);
    check("R3", "reg07 written", dev[7], 16'h7C04);
    check("R4", "reg04 written", dev[4], 16'h002A);
    check("R5", "reg02 written", lastWr2, 16'h0041);
    check("R6", "partial writes", partial, 0);
    check("R2", "tx0 rd07", txLog[0], 14);
    check("R2", "tx1 wr07", txLog[1], 15);
    check("R2", "tx2 rd04", txLog[2], 8);
    check("R2", "tx3 wr04", txLog[3], 9);
    check("R2", "tx4 rd02", txLog[4], 4);
    check("R2", "tx5 wr02", txLog[5], 5);
    check("R2", "tx6 poll02", txLog[6], 4);

    // Scenario B: option off, latency 3, extra start pulses while busy
    prep(3, 25, 16'h1234, 16'hFFFF, 16'hFFBE);
    pulseStart(1'b0);
    repeat (3) @(negedge clk);
    pulseStart(1'b1);
    repeat (12) @(negedge clk);
    pulseStart(1'b1);
    waitEnd();
    check("R10", "reg07 untouched", dev[7], 16'h1234);
    check("R10", "reg07 writes", wrCount[7], 0);
    check("R2", "first tx is rd04", txLog[0], 8);
    check("R4", "reg04 written", dev[4], 16'hFFEE);
    check("R5", "reg02 written", lastWr2, 16'h7FFF);
    check("R8", "done seen", sawDone, 1);

    // Scenario C: device never clears, latency 0 -> timeout
    prep(0, -1, 16'h0000, 16'h0000, 16'h0000);
    pulseStart(1'b1);
    waitEnd();
    check("R9", "timeout seen", sawTo, 1);
    check("R9", "no done", sawDone, 0);
    check("R9", "idle after timeout", {busy, busWrReq, busRdReq}, 0);
    check("R6", "partial writes", partial, 0);
    check("R3", "reg07 bit14", dev[7][14], 1);

    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule